// File: doc/BRIEF.md
# Memory Error Capture Registers

This block sits beside a memory data path and records error-correction events for software. Each cycle the path may report a single-bit (corrected) event, a multi-bit (uncorrectable) event, or both, together with the full byte address and the 3-bit memory row involved. The block keeps the 4 KB page of the first logged event with one pending flag per error class, a status word with sticky per-class occurrence flags and the row of the first event of each class, and a small command word that routes each class to a level-sensitive system-error output.

Software reaches the three words through a flat register port: a 2-bit selector, a write strobe with write data, and a combinational read bus. All flags are cleared by writing one to them. The page register is governed by a two-state capture machine. In `CAP_EMPTY` the page is free. The `ARM` transition fires on any event: it loads the page and enters `CAP_HELD`. In `CAP_HELD`, the `HOLD` transition keeps the page while any pending flag remains set. The `RELEASE` transition returns to `CAP_EMPTY` when software clears the last pending flag and no event arrives. The `RELOAD` transition stays in `CAP_HELD` and loads a new page when the last flag is cleared in the same cycle that an event arrives.

Top module: `mecr_top`

## Requirements
- R1: After reset every readable field is zero and `serr_o` is low.
- R2: An event sets its pending flag in the page register one clock later. Single-bit uses bit 0 and multi-bit uses bit 1 (selector 0).
- R3: An event accepted in `CAP_EMPTY` places address bits 31:12 in bits 31:12 of the page register. Bits 11:2 always read zero.
- R4: While either pending flag stays set, later events leave bits 31:12 unchanged. They still set their own class flag.
- R5: Writing one to bit 0 or bit 1 of the page register clears that flag, and writing zero leaves it. An event takes priority over a clear of its own flag. Once no flag remains set, the next event is captured, and this includes an event in the same cycle as the clearing write.
- R6: The status word (selector 1) has these fields: bit 0 is the single-bit occurred flag, bits 3:1 are the row of the first single-bit event, bit 4 is the multi-bit occurred flag, and bits 7:5 are the row of the first multi-bit event. Bits 31:8 read zero.
- R7: A row field is frozen while its class flag is set. Status flags clear by writing one to bit 0 or bit 4. The next event of that class after the clear loads its row.
- R8: When both classes arrive in the same cycle, both page flags and both status flags set, the page comes from that event, and both rows take its row.
- R9: The command word (selector 2) holds bits 1:0 as written. Bit 0 enables single-bit and bit 1 enables multi-bit. Its other bits read zero.
- R10: `serr_o` is high exactly while an enabled class has its status flag set.
- R11: Selector 3 reads zero, and writes to it change no field.
- R12: Page-register flags and status flags are independent. Clearing one set leaves the other set as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_single | input | 1 | Single-bit error event this cycle |
| ev_multi | input | 1 | Multi-bit error event this cycle |
| ev_addr | input | 32 | Byte address of the event |
| ev_row | input | 3 | Memory row of the event |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector: 0 page, 1 status, 2 command, 3 none |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents, combinational |
| serr_o | output | 1 | System-error level |

## Verification
The assertions assume that the event strobes, address and row are valid on every clock edge after reset, and that a write is a single-cycle strobe whose selector and data are stable at the edge. The row-freeze and output-raise properties exclude cycles in which software writes the same register. The random stimulus keeps every input at a defined 0/1 value and changes them only between edges. It makes events sparse so that the flags spend time both set and clear. It also lets writes land on every selector, including in the same cycle as events.

// File: rtl/mecr_pkg.sv
`timescale 1ns/1ps
package mecr_pkg;

    typedef enum logic [1:0] {
        SEL_PAGE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CAP_EMPTY = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_e;

    localparam int N_CLASS    = 2;
    localparam int CLS_SINGLE = 0;
    localparam int CLS_MULTI  = 1;

endpackage

// File: rtl/mecr_page_capture.sv
`timescale 1ns/1ps
module mecr_page_capture
    import mecr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 12,
    localparam int PG_W    = ADDR_W - PAGE_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CLASS-1:0] evt,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [N_CLASS-1:0] clr,
    output logic [N_CLASS-1:0] flags,
    output logic [PG_W-1:0]    page,
    output logic               held
);

    cap_state_e         state_q, state_d;
    logic [N_CLASS-1:0] keep;
    logic               load_page;

    assign keep = flags & ~clr;

    // next-state: ARM, HOLD, RELEASE, RELOAD
    always_comb begin
        state_d   = state_q;
        load_page = 1'b0;
        unique case (state_q)
            CAP_EMPTY: begin
                if (|evt) begin
                    state_d   = CAP_HELD;   // ARM
                    load_page = 1'b1;
                end
            end
            CAP_HELD: begin
                if (keep == '0) begin
                    if (|evt) begin
                        state_d   = CAP_HELD;  // RELOAD
                        load_page = 1'b1;
                    end else begin
                        state_d   = CAP_EMPTY; // RELEASE
                    end
                end else begin
                    state_d = CAP_HELD;        // HOLD
                end
            end
            default: state_d = CAP_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_EMPTY;
        else        state_q <= state_d;
    end

    // outputs: flags and captured page
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            page  <= '0;
        end else begin
            flags <= keep | evt;
            if (load_page) page <= addr[ADDR_W-1:PAGE_LSB];
        end
    end

    assign held = (state_q == CAP_HELD);

    logic unused_addr_low;
    assign unused_addr_low = ^addr[PAGE_LSB-1:0];

endmodule

// File: rtl/mecr_status_log.sv
`timescale 1ns/1ps
module mecr_status_log
    import mecr_pkg::*;
#(
    parameter int ROW_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_CLASS-1:0]             evt,
    input  logic [ROW_W-1:0]               row,
    input  logic [N_CLASS-1:0]             clr,
    output logic [N_CLASS-1:0]             flags,
    output logic [N_CLASS-1:0][ROW_W-1:0]  rows
);

    for (genvar c = 0; c < N_CLASS; c++) begin : g_cls
        logic keep_c;
        assign keep_c = flags[c] & ~clr[c];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[c] <= 1'b0;
                rows[c]  <= '0;
            end else begin
                flags[c] <= keep_c | evt[c];
                if (evt[c] && !keep_c) rows[c] <= row;
            end
        end
    end

endmodule

// File: rtl/mecr_cmd_ctl.sv
`timescale 1ns/1ps
module mecr_cmd_ctl
    import mecr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [N_CLASS-1:0] wdata,
    input  logic [N_CLASS-1:0] sts_flags,
    output logic [N_CLASS-1:0] cmd_en,
    output logic               serr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cmd_en <= '0;
        else if (wr_en) cmd_en <= wdata;
    end

    assign serr = |(cmd_en & sts_flags);

endmodule

// File: rtl/mecr_top.sv
`timescale 1ns/1ps
module mecr_top
    import mecr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 12,
    parameter int ROW_W    = 3,
    localparam int PG_W    = ADDR_W - PAGE_LSB,
    localparam int STAT_W  = N_CLASS * (ROW_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_single,
    input  logic              ev_multi,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [ROW_W-1:0]  ev_row,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              serr_o
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(cfg_sel);

    logic [N_CLASS-1:0] evt;
    assign evt[CLS_SINGLE] = ev_single;
    assign evt[CLS_MULTI]  = ev_multi;

    logic [N_CLASS-1:0] pg_clr, st_clr;
    logic               cmd_wr;
    assign pg_clr[CLS_SINGLE] = cfg_wr && (sel == SEL_PAGE) && cfg_wdata[0];
    assign pg_clr[CLS_MULTI]  = cfg_wr && (sel == SEL_PAGE) && cfg_wdata[1];
    assign st_clr[CLS_SINGLE] = cfg_wr && (sel == SEL_STAT) && cfg_wdata[0];
    assign st_clr[CLS_MULTI]  = cfg_wr && (sel == SEL_STAT) && cfg_wdata[ROW_W+1];
    assign cmd_wr             = cfg_wr && (sel == SEL_CMD);

    logic [N_CLASS-1:0]            a_flags;
    logic [PG_W-1:0]               a_page;
    logic                          a_held;
    logic [N_CLASS-1:0]            s_flags;
    logic [N_CLASS-1:0][ROW_W-1:0] s_rows;
    logic [N_CLASS-1:0]            cmd_en;

    mecr_page_capture #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .addr  (ev_addr),
        .clr   (pg_clr),
        .flags (a_flags),
        .page  (a_page),
        .held  (a_held)
    );

    mecr_status_log #(.ROW_W(ROW_W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .row   (ev_row),
        .clr   (st_clr),
        .flags (s_flags),
        .rows  (s_rows)
    );

    mecr_cmd_ctl u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cmd_wr),
        .wdata     (cfg_wdata[N_CLASS-1:0]),
        .sts_flags (s_flags),
        .cmd_en    (cmd_en),
        .serr      (serr_o)
    );

    logic [STAT_W-1:0] stat_word;
    always_comb begin
        for (int c = 0; c < N_CLASS; c++) begin
            stat_word[c*(ROW_W+1)]                  = s_flags[c];
            stat_word[c*(ROW_W+1)+1 +: ROW_W]       = s_rows[c];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (sel)
            SEL_PAGE: begin
                cfg_rdata[ADDR_W-1:PAGE_LSB] = a_page;
                cfg_rdata[N_CLASS-1:0]       = a_flags;
            end
            SEL_STAT: cfg_rdata[STAT_W-1:0]  = stat_word;
            SEL_CMD:  cfg_rdata[N_CLASS-1:0] = cmd_en;
            SEL_NONE: cfg_rdata = '0;
            default:  cfg_rdata = '0;
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^{cfg_wdata[ADDR_W-1:ROW_W+2], cfg_wdata[ROW_W:2], a_held};

endmodule

// File: rtl/mecr_checker.sv
`timescale 1ns/1ps
module mecr_checker
    import mecr_pkg::*;
#(
    parameter int PG_W  = 20,
    parameter int ROW_W = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           ev_single,
    input logic                           ev_multi,
    input logic                           cfg_wr,
    input logic [1:0]                     cfg_sel,
    input logic [31:0]                    cfg_wdata,
    input logic                           serr_o,
    input logic [N_CLASS-1:0]             a_flags,
    input logic [PG_W-1:0]                a_page,
    input logic                           a_held,
    input logic [N_CLASS-1:0]             s_flags,
    input logic [N_CLASS-1:0][ROW_W-1:0]  s_rows,
    input logic [N_CLASS-1:0]             cmd_en
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (a_flags == '0 && s_flags == '0 && cmd_en == '0 && !serr_o));

    // R2
    single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_single |=> a_flags[CLS_SINGLE]);

    // R2
    multi_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_multi |=> a_flags[CLS_MULTI]);

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_held && !(cfg_wr && cfg_sel == 2'd0)) |=> $stable(a_page));

    // R5
    held_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_held == (|a_flags));

    // R7
    row_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_flags[CLS_SINGLE] && !(cfg_wr && cfg_sel == 2'd1 && cfg_wdata[0]))
        |=> $stable(s_rows[CLS_SINGLE]));

    // R10
    serr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_multi && cmd_en[CLS_MULTI] && !(cfg_wr && cfg_sel == 2'd2)) |=> serr_o);

    // R10
    serr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_flags == '0) |-> !serr_o);

endmodule

bind mecr_top mecr_checker #(.PG_W(PG_W), .ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_single (ev_single),
    .ev_multi  (ev_multi),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .serr_o    (serr_o),
    .a_flags   (a_flags),
    .a_page    (a_page),
    .a_held    (a_held),
    .s_flags   (s_flags),
    .s_rows    (s_rows),
    .cmd_en    (cmd_en)
);

// File: tb/sim_mecr_top.sv
`timescale 1ns/1ps
module sim_mecr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_single = 1'b0, ev_multi = 1'b0;
    logic [31:0] ev_addr = '0;
    logic [2:0]  ev_row = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        serr_o;

    always #4 clk = ~clk;

    mecr_top u0 (
        .clk(clk), .rst_n(rst_n), .ev_single(ev_single), .ev_multi(ev_multi),
        .ev_addr(ev_addr), .ev_row(ev_row), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .serr_o(serr_o)
    );

    int vecs = 0;
    int errs = 0;

    // expected state, built from the requirements
    logic [1:0]  m_aflag = '0;
    logic [19:0] m_page  = '0;
    logic [1:0]  m_sflag = '0;
    logic [2:0]  m_row0  = '0, m_row1 = '0;
    logic [1:0]  m_cmd   = '0;

    function automatic logic [31:0] exp_read(input logic [1:0] s);
        case (s)
            2'd0:    return {m_page, 10'd0, m_aflag};
            2'd1:    return {24'd0, m_row1, m_sflag[1], m_row0, m_sflag[0]};
            2'd2:    return {30'd0, m_cmd};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_serr();
        return |(m_cmd & m_sflag);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // drive inputs for the next edge and advance the expected state
    task automatic apply(input logic s, input logic m, input logic [31:0] a,
                         input logic [2:0] r, input logic w, input logic [1:0] sl,
                         input logic [31:0] wd);
        logic [1:0] evt, clr_a, clr_s, keep_a;
        ev_single = s; ev_multi = m; ev_addr = a; ev_row = r;
        cfg_wr = w; cfg_sel = sl; cfg_wdata = wd;
        evt   = {m, s};
        clr_a = (w && sl == 2'd0) ? wd[1:0] : 2'b00;
        clr_s = (w && sl == 2'd1) ? {wd[4], wd[0]} : 2'b00;
        keep_a = m_aflag & ~clr_a;
        if (evt != 2'b00 && keep_a == 2'b00) m_page = a[31:12];
        m_aflag = keep_a | evt;
        if (s && !(m_sflag[0] & ~clr_s[0])) m_row0 = r;
        if (m && !(m_sflag[1] & ~clr_s[1])) m_row1 = r;
        m_sflag = (m_sflag & ~clr_s) | evt;
        if (w && sl == 2'd2) m_cmd = wd[1:0];
    endtask

    // after the edge, sweep every selector and compare
    task automatic verify(input string tag);
        @(posedge clk);
        #1;
        ev_single = 0; ev_multi = 0; cfg_wr = 0;
        for (int s = 0; s < 4; s++) begin
            cfg_sel = s[1:0];
            #1;
            chk(tag, cfg_rdata, exp_read(s[1:0]));
        end
        chk({tag, " serr"}, {31'd0, serr_o}, {31'd0, exp_serr()});
    endtask

    task automatic step(input string tag, input logic s, input logic m, input logic [31:0] a,
                        input logic [2:0] r, input logic w, input logic [1:0] sl,
                        input logic [31:0] wd);
        apply(s, m, a, r, w, sl, wd);
        verify(tag);
    endtask

    initial begin
        #(8 * 150000);
        errs++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step("R1 reset", 0, 0, 0, 0, 0, 0, 0);

        step("R2 R3 R6 first single", 1, 0, 32'h1234_5ABC, 3'd5, 0, 0, 0);
        step("R4 R6 multi held page", 0, 1, 32'hFFFF_F000, 3'd2, 0, 0, 0);
        step("R7 row frozen", 1, 0, 32'h0000_1000, 3'd7, 0, 0, 0);
        step("R5 clear single only", 0, 0, 0, 0, 1, 2'd0, 32'h1);
        step("R5 write zero no effect", 0, 0, 0, 0, 1, 2'd0, 32'h0);
        step("R12 status kept", 0, 0, 0, 0, 0, 0, 0);
        step("R5 reload on last clear", 1, 0, 32'hABCD_E777, 3'd1, 1, 2'd0, 32'h2);
        step("R5 event beats clear", 1, 0, 32'h5555_5000, 3'd4, 1, 2'd0, 32'h1);
        step("R7 clear status", 0, 0, 0, 0, 1, 2'd1, 32'h11);
        step("R12 page flags kept", 0, 0, 0, 0, 0, 0, 0);
        step("R7 new row after clear", 1, 0, 32'h0, 3'd3, 0, 0, 0);
        step("R8 prep clear", 0, 0, 0, 0, 1, 2'd0, 32'h3);
        step("R8 prep clear status", 0, 0, 0, 0, 1, 2'd1, 32'h11);
        step("R8 both classes", 1, 1, 32'h8000_0123, 3'd6, 0, 0, 0);
        step("R9 command write", 0, 0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF);
        step("R10 serr with enables", 0, 0, 0, 0, 0, 0, 0);
        step("R10 clear single status", 0, 0, 0, 0, 1, 2'd1, 32'h01);
        step("R10 enable single only", 0, 0, 0, 0, 1, 2'd2, 32'h1);
        step("R11 dead selector write", 0, 0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
        step("R10 serr drop", 0, 0, 0, 0, 1, 2'd1, 32'h10);

        for (int i = 0; i < 800; i++) begin
            logic s, m, w;
            s = ($urandom % 6) == 0;
            m = ($urandom % 8) == 0;
            w = ($urandom % 4) == 0;
            apply(s, m, $urandom, 3'($urandom), w, 2'($urandom), $urandom);
            verify("random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule